// File: doc/BRIEF.md
# Three-Register Exchange Sequencer

The block holds three data registers on one shared bus: an A register, a B register and a scratch register T. A controller swaps the contents of A and B, with T as the temporary store. A pulse on `start_i` while the controller rests begins the swap. The controller then makes three bus transfers, one per clock. In each transfer exactly one register drives the bus and exactly one register captures it.

The bus is a multiplexer, not a tri-state net. It carries the register whose drive enable is active, and reads zero when no enable is active. A side load port writes A or B directly, so the surrounding logic (or a bench) can set up operands. That port is honoured only while the controller rests. The drive and capture enables and the completion flag are Moore outputs: they depend only on the present step of the sequence.

Top module: `reg_swap_unit`

## Requirements
- R1: After reset the controller is at rest: `drive_o`, `latch_o` and `done_o` are 0, all three registers hold 0 and `bus_o` reads 0.
- R2: At rest with `start_i` low, the controller stays at rest with all enables 0. With `start_i` high at a clock edge, it enters the first transfer step at that edge.
- R3: In the first transfer step, B drives the bus and T captures it (`drive_o`=3'b010, `latch_o`=3'b100; bit 0 is A, bit 1 is B, bit 2 is T).
- R4: In the second transfer step, A drives the bus and B captures it (`drive_o`=3'b001, `latch_o`=3'b010).
- R5: In the third transfer step, T drives the bus, A captures it and `done_o` is 1 (`drive_o`=3'b100, `latch_o`=3'b001). `done_o` is 0 in every other step.
- R6: Once started, the sequence advances one step per clock edge whatever `start_i` does, and returns to rest after the third step.
- R7: `bus_o` equals the register selected by the single active bit of `drive_o`. It is 0 when `drive_o` is 0. At most one drive bit and at most one capture bit are ever set.
- R8: With `load_en_i` high at an edge while at rest, `load_data_i` is written into A when `load_sel_i`=0, or into B when `load_sel_i`=1. During a swap the side port is ignored and no register changes through it.
- R9: After a complete swap, A holds the former B, B holds the former A, and T holds the former B.
- R10: A side load and a start at the same edge are both accepted. The swap then operates on the freshly loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a swap when the controller is at rest |
| load_en_i | input | 1 | Side load write strobe |
| load_sel_i | input | 1 | Side load target: 0 selects A, 1 selects B |
| load_data_i | input | DATA_W | Side load value |
| bus_o | output | DATA_W | Shared bus value |
| reg_a_o | output | DATA_W | Contents of A |
| reg_b_o | output | DATA_W | Contents of B |
| reg_t_o | output | DATA_W | Contents of T |
| drive_o | output | 3 | Bus drive enables (bit 0 A, bit 1 B, bit 2 T) |
| latch_o | output | 3 | Bus capture enables (same bit order) |
| done_o | output | 1 | High during the final transfer step |

## Verification
Two functions can meet in one cycle. The side load can write B on the very edge at which a start is taken, and the first transfer then reads B onto the bus. The bench raises the load strobe and the start together while the controller rests. It expects both the new B value on the bus in the first step and that value ending up in A and T. A second collision is a side load attempted during a swap, which must lose to the transfer sequence. That is judged by the register outputs staying at the values the swap alone predicts.

// File: rtl/swap_pkg.sv
package swap_pkg;

    // Register slots on the shared bus; bit positions of drive/latch vectors.
    localparam int NREG  = 3;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_T = 2;

    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_TO_T  = 2'd1,
        ST_TO_B  = 2'd2,
        ST_TO_A  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [NREG-1:0] drv;
        logic [NREG-1:0] ld;
        logic            done;
    } xfer_ctl_t;

    // Moore decode of one sequencer step into its bus enables.
    function automatic xfer_ctl_t step_decode(seq_state_e s);
        xfer_ctl_t c;
        c = '0;
        case (s)
            ST_TO_T: begin
                c.drv[IDX_B] = 1'b1;
                c.ld[IDX_T]  = 1'b1;
            end
            ST_TO_B: begin
                c.drv[IDX_A] = 1'b1;
                c.ld[IDX_B]  = 1'b1;
            end
            ST_TO_A: begin
                c.drv[IDX_T] = 1'b1;
                c.ld[IDX_A]  = 1'b1;
                c.done       = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/swap_seq.sv
module swap_seq
    import swap_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    output xfer_ctl_t ctl_o,
    output logic      rest_o
);

    typedef struct packed {
        seq_state_e st;
        xfer_ctl_t  ctl;
        logic       rest;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_REST: seq_d.st = start_i ? ST_TO_T : ST_REST;
            ST_TO_T: seq_d.st = ST_TO_B;
            ST_TO_B: seq_d.st = ST_TO_A;
            default: seq_d.st = ST_REST;
        endcase
        // Enables are decoded from the next step and registered with it.
        seq_d.ctl  = step_decode(seq_d.st);
        seq_d.rest = (seq_d.st == ST_REST);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.st   <= ST_REST;
            seq_q.ctl  <= '0;
            seq_q.rest <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctl_o  = seq_q.ctl;
    assign rest_o = seq_q.rest;

endmodule

// File: rtl/swap_regfile.sv
module swap_regfile
    import swap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NREG-1:0]            ld_i,
    input  logic [DATA_W-1:0]          bus_i,
    input  logic                       side_we_i,
    input  logic                       side_sel_i,
    input  logic [DATA_W-1:0]          side_data_i,
    output logic [NREG-1:0][DATA_W-1:0] regs_o
);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] val;
    } file_t;

    file_t file_d, file_q;
    logic [NREG-1:0] side_hit;

    // Side port reaches A (sel 0) and B (sel 1); T is bus-only.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_hit
        if (gi == IDX_A) begin : g_a
            assign side_hit[gi] = side_we_i & ~side_sel_i;
        end else if (gi == IDX_B) begin : g_b
            assign side_hit[gi] = side_we_i & side_sel_i;
        end else begin : g_none
            assign side_hit[gi] = 1'b0;
        end
    end

    always_comb begin
        file_d = file_q;
        for (int i = 0; i < NREG; i++) begin
            if (ld_i[i]) begin
                file_d.val[i] = bus_i;
            end else if (side_hit[i]) begin
                file_d.val[i] = side_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            file_q <= '0;
        end else begin
            file_q <= file_d;
        end
    end

    assign regs_o = file_q.val;

endmodule

// File: rtl/swap_bus.sv
module swap_bus
    import swap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NREG-1:0]             drv_i,
    input  logic [NREG-1:0][DATA_W-1:0] regs_i,
    output logic [DATA_W-1:0]           bus_o
);

    // AND-OR multiplexer: zero when no source is enabled.
    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NREG; i++) begin
            bus_o = bus_o | (regs_i[i] & {DATA_W{drv_i[i]}});
        end
    end

endmodule

// File: rtl/reg_swap_unit.sv
module reg_swap_unit
    import swap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              load_en_i,
    input  logic              load_sel_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] reg_a_o,
    output logic [DATA_W-1:0] reg_b_o,
    output logic [DATA_W-1:0] reg_t_o,
    output logic [2:0]        drive_o,
    output logic [2:0]        latch_o,
    output logic              done_o
);

    xfer_ctl_t                   ctl;
    logic                        at_rest;
    logic                        side_we;
    logic [DATA_W-1:0]           bus;
    logic [NREG-1:0][DATA_W-1:0] regs;

    swap_seq u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .ctl_o   (ctl),
        .rest_o  (at_rest)
    );

    assign side_we = load_en_i & at_rest;

    swap_regfile #(.DATA_W(DATA_W)) u_file (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ld_i        (ctl.ld),
        .bus_i       (bus),
        .side_we_i   (side_we),
        .side_sel_i  (load_sel_i),
        .side_data_i (load_data_i),
        .regs_o      (regs)
    );

    swap_bus #(.DATA_W(DATA_W)) u_bus (
        .drv_i  (ctl.drv),
        .regs_i (regs),
        .bus_o  (bus)
    );

    assign bus_o   = bus;
    assign reg_a_o = regs[IDX_A];
    assign reg_b_o = regs[IDX_B];
    assign reg_t_o = regs[IDX_T];
    assign drive_o = ctl.drv;
    assign latch_o = ctl.ld;
    assign done_o  = ctl.done;

endmodule

// File: rtl/swap_checker.sv
module swap_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [DATA_W-1:0] bus_o,
    input logic [DATA_W-1:0] reg_a_o,
    input logic [DATA_W-1:0] reg_b_o,
    input logic [DATA_W-1:0] reg_t_o,
    input logic [2:0]        drive_o,
    input logic [2:0]        latch_o,
    input logic              done_o
);

    assert_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(drive_o) && $onehot0(latch_o));

    assert_idle_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_o == 3'b000) |-> (bus_o == '0));

    assert_bus_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_o[1] |-> (bus_o == reg_b_o));

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_o == 3'b000 && !start_i) |=> (drive_o == 3'b000 && latch_o == 3'b000));

    assert_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_o == 3'b000 && start_i) |=> (drive_o == 3'b010 && latch_o == 3'b100));

    assert_step2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch_o == 3'b100) |=> (drive_o == 3'b001 && latch_o == 3'b010));

    assert_step3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch_o == 3'b010) |=> (done_o && drive_o == 3'b100 && latch_o == 3'b001));

    assert_done_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (latch_o == 3'b001));

    assert_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (drive_o == 3'b000 && !done_o));

    assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_o[0] |=> (reg_a_o == $past(bus_o)));

    assert_side_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_o[2] |=> $stable(reg_a_o));

endmodule

bind reg_swap_unit swap_checker #(.DATA_W(DATA_W)) u_swap_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bus_o   (bus_o),
    .reg_a_o (reg_a_o),
    .reg_b_o (reg_b_o),
    .reg_t_o (reg_t_o),
    .drive_o (drive_o),
    .latch_o (latch_o),
    .done_o  (done_o)
);

// File: tb/reg_swap_unit_tb.sv
module reg_swap_unit_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_i = 1'b0;
    logic         load_en_i = 1'b0;
    logic         load_sel_i = 1'b0;
    logic [W-1:0] load_data_i = '0;
    logic [W-1:0] bus_o, reg_a_o, reg_b_o, reg_t_o;
    logic [2:0]   drive_o, latch_o;
    logic         done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    reg_swap_unit #(.DATA_W(W)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .load_en_i   (load_en_i),
        .load_sel_i  (load_sel_i),
        .load_data_i (load_data_i),
        .bus_o       (bus_o),
        .reg_a_o     (reg_a_o),
        .reg_b_o     (reg_b_o),
        .reg_t_o     (reg_t_o),
        .drive_o     (drive_o),
        .latch_o     (latch_o),
        .done_o      (done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled 2 ns after the edge.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic side_load(input logic sel, input logic [W-1:0] v);
        load_en_i = 1'b1; load_sel_i = sel; load_data_i = v;
        step();
        load_en_i = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] va, vb, vx;
        repeat (3) step();
        // R1: reset state
        chk("R1 drive", int'(drive_o), 0);
        chk("R1 latch", int'(latch_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 regA", int'(reg_a_o), 0);
        chk("R1 regB", int'(reg_b_o), 0);
        chk("R1 regT", int'(reg_t_o), 0);
        chk("R1 bus", int'(bus_o), 0);
        rst_ni = 1'b1;
        step();

        // R8: side loads at rest
        va = 4'h5; vb = 4'hC;
        side_load(1'b0, va);
        side_load(1'b1, vb);
        chk("R8 load A", int'(reg_a_o), int'(va));
        chk("R8 load B", int'(reg_b_o), int'(vb));

        // R2: rest holds while start low
        repeat (3) step();
        chk("R2 hold drive", int'(drive_o), 0);
        chk("R2 hold latch", int'(latch_o), 0);
        chk("R7 bus zero", int'(bus_o), 0);

        // Directed swap, start held high, side load attempted mid-swap
        start_i = 1'b1;
        step();
        chk("R2 launch", int'(latch_o), 3'b100);
        chk("R3 drive", int'(drive_o), 3'b010);
        chk("R3 latch", int'(latch_o), 3'b100);
        chk("R7 bus B", int'(bus_o), int'(vb));
        chk("R5 done low step1", int'(done_o), 0);
        load_en_i = 1'b1; load_sel_i = 1'b0; load_data_i = ~va;
        step();
        chk("R3 T captured", int'(reg_t_o), int'(vb));
        chk("R8 ignored A", int'(reg_a_o), int'(va));
        chk("R4 drive", int'(drive_o), 3'b001);
        chk("R4 latch", int'(latch_o), 3'b010);
        chk("R7 bus A", int'(bus_o), int'(va));
        load_sel_i = 1'b1; load_data_i = ~vb;
        step();
        load_en_i = 1'b0;
        chk("R4 B captured", int'(reg_b_o), int'(va));
        chk("R8 ignored B", int'(reg_b_o), int'(va));
        chk("R5 drive", int'(drive_o), 3'b100);
        chk("R5 latch", int'(latch_o), 3'b001);
        chk("R5 done", int'(done_o), 1);
        chk("R7 bus T", int'(bus_o), int'(vb));
        start_i = 1'b0;
        step();
        chk("R6 rest", int'(drive_o), 0);
        chk("R6 done low", int'(done_o), 0);
        chk("R9 A", int'(reg_a_o), int'(vb));
        chk("R9 B", int'(reg_b_o), int'(va));
        chk("R9 T", int'(reg_t_o), int'(vb));

        // R10: side load of B and start on the same edge
        vx = 4'h9;
        load_en_i = 1'b1; load_sel_i = 1'b1; load_data_i = vx; start_i = 1'b1;
        step();
        load_en_i = 1'b0; start_i = 1'b0;
        chk("R10 B loaded", int'(reg_b_o), int'(vx));
        chk("R10 bus new B", int'(bus_o), int'(vx));
        repeat (3) step();
        chk("R10 A", int'(reg_a_o), int'(vx));
        chk("R10 B", int'(reg_b_o), int'(vb));
        chk("R10 T", int'(reg_t_o), int'(vx));

        // Exhaustive sweep of operand pairs, one-cycle start pulse
        for (int pa = 0; pa < (1 << W); pa++) begin
            for (int pb = 0; pb < (1 << W); pb++) begin
                side_load(1'b0, W'(pa));
                side_load(1'b1, W'(pb));
                start_i = 1'b1;
                step();
                start_i = 1'b0;
                step();
                step();
                chk("R5 sweep done", int'(done_o), 1);
                step();
                chk("R6 sweep rest", int'(drive_o), 0);
                chk("R9 sweep A", int'(reg_a_o), pb);
                chk("R9 sweep B", int'(reg_b_o), pa);
                chk("R9 sweep T", int'(reg_t_o), pb);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule